// File: doc/BRIEF.md
# Video Interrupt and Control Register File

This block is the halfword register file that sits between a processor bus and a display controller. It holds the interrupt pending and enable registers, a write-only clear port for pending bits, and control and status registers for the display and drawing sides. It also holds three brightness levels, four background palettes, four object palettes, four object-group pointers, a backdrop colour, and a few plain holding registers. A rendering engine reads the register outputs. Event pulses from the display pipeline enter on `evtSet` and set pending bits. `irqOut` is the level interrupt to the processor.

The bus address is first folded into the register window. Only address bits 1 to 6 pick a register; bits 16 and 18 and bits 11 to 15 are forced high; every other bit is dropped. Reads are combinational halfword reads. A halfword write takes effect at the clock edge where it is presented. A word write is split in two. The low half goes to the given address on the first edge. The high half goes to the address plus two on the next edge, and `busy` is high during that second cycle.

The control writes have side effects. Setting bit 0 of a display or drawing control write resets part of the interrupt state. The pending and enable registers are then cut down to the bits that belong to the other side. Brightness and palette writes raise one-cycle change strobes so that the renderer can refresh its cached colour tables.

Top module: `vid_irq_regfile`

## Requirements
- R1: After reset, every register reads zero, `irqOut`, `busy` and all three change strobes are low, and every register output is zero.
- R2: A halfword write to offset 0x04 (clear port) clears in the pending register each bit that is set in the data. Reading offset 0x04 returns 0.
- R3: Each set bit of `evtSet` sets the same pending bit at the next edge, even when a clear or a reset mask is applied in that cycle. `irqOut` is high exactly when pending AND enable is non-zero.
- R4: A write to offset 0x22 (display control) stores data AND 0x0703. Display status at offset 0x20 becomes (data AND 0x0702) OR (previous status AND 0x00FC).
- R5: A display control write with bit 0 set leaves only bits 13 and 14 (mask 0x6000) in both pending and enable.
- R6: A write to offset 0x42 (drawing control) stores data AND 0x1F03. Drawing status at offset 0x40 becomes (previous status AND 0x9F1C) OR (data AND 0x0002).
- R7: A drawing control write with bit 0 set leaves only bits 0 to 4 (mask 0x001F) in both pending and enable.
- R8: A write to offset 0x24, 0x26 or 0x28 stores (data AND 0x00FF) OR 0x0100 in brightness level 0, 1 or 2. Level 0 drives `brightOut[15:0]` and level 2 drives `brightOut[47:32]`. `brtChg` is high for the one cycle after the write.
- R9: A write to a background palette (offsets 0x60 to 0x66) pulses `bgPalChg`. A write to an object palette (offsets 0x68 to 0x6E) pulses `objPalChg`. A write to the backdrop colour (0x70) pulses both. Each pulse lasts one cycle, and the written value is stored unchanged. Palette n drives bits [16n+15:16n] of its output.
- R10: Writes to offset 0x00 (pending), 0x20 (display status) and 0x40 (drawing status) change nothing. A read of any offset that holds no register returns 0xFFFF.
- R11: The register is selected by (address AND 0x5007E) OR 0x5F800. Two addresses that agree in bits 1 to 6 reach the same register.
- R12: A word write stores `wrData[15:0]` at the address on the first edge and `wrData[31:16]` at the address plus two on the next edge. `busy` is high for that one second cycle, and any write presented while `busy` is high is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte address of the access |
| wrEn | input | 1 | Write request for this cycle |
| accWord | input | 1 | 1 = 32-bit write, 0 = halfword write |
| wrData | input | 32 | Write data; low half used for halfword writes |
| evtSet | input | 16 | Event pulses that set pending bits |
| rdData | output | 16 | Combinational read data for busAddr |
| busy | output | 1 | High during the high-half cycle of a word write |
| irqOut | output | 1 | Interrupt request, pending AND enable non-zero |
| pendOut | output | 16 | Pending register |
| enabOut | output | 16 | Enable register |
| dispCtlOut | output | 16 | Display control register |
| dispStatOut | output | 16 | Display status register |
| drawCtlOut | output | 16 | Drawing control register |
| drawStatOut | output | 16 | Drawing status register |
| brightOut | output | 48 | Three brightness levels, level 0 lowest |
| bgPalOut | output | 64 | Four background palettes |
| objPalOut | output | 64 | Four object palettes |
| sprPtrOut | output | 64 | Four object-group pointers |
| backColOut | output | 16 | Backdrop colour |
| brtChg | output | 1 | One-cycle pulse after a brightness write |
| bgPalChg | output | 1 | One-cycle pulse after a background palette or backdrop write |
| objPalChg | output | 1 | One-cycle pulse after an object palette or backdrop write |

## Verification
The interrupt state is driven with events alone, clears alone, and an event and a clear on the same bit in the same cycle. Together these show that an event overrides a clear. Each control register gets a write with bit 0 set and a write with bit 0 clear, using all-ones data where possible. This separates the stored-field masks from the pruning masks, and it shows that pruning happens only when bit 0 is set. Word writes are aimed at the enable/clear pair, so the high half has a visible effect on the interrupt state. A stray write during the busy cycle shows that it is dropped. Aliased high addresses and unused offsets exercise the address fold and the 0xFFFF read value.

// File: rtl/vreg_pkg.sv
package vreg_pkg;

  localparam int HW        = 16;
  localparam int NUM_BANK  = 4;
  localparam int NUM_BRT   = 3;

  // address folding
  localparam logic [31:0] FOLD_KEEP = 32'h0005_007E;
  localparam logic [31:0] FOLD_SET  = 32'h0005_F800;

  // field masks
  localparam logic [HW-1:0] DCTL_KEEP  = 16'h0703;
  localparam logic [HW-1:0] DSTAT_NEW  = 16'h0702;
  localparam logic [HW-1:0] DSTAT_OLD  = 16'h00FC;
  localparam logic [HW-1:0] DRST_MASK  = 16'h6000;
  localparam logic [HW-1:0] XCTL_KEEP  = 16'h1F03;
  localparam logic [HW-1:0] XSTAT_NEW  = 16'h0002;
  localparam logic [HW-1:0] XSTAT_OLD  = 16'h9F1C;
  localparam logic [HW-1:0] XRST_MASK  = 16'h001F;
  localparam logic [HW-1:0] BRT_FIXED  = 16'h0100;
  localparam logic [HW-1:0] BRT_DATA   = 16'h00FF;
  localparam logic [HW-1:0] NO_REG_VAL = 16'hFFFF;

  typedef enum logic [4:0] {
    SEL_NONE, SEL_PEND, SEL_ENAB, SEL_CLR, SEL_DSTAT, SEL_DCTL,
    SEL_BRT0, SEL_BRT1, SEL_BRT2, SEL_REST, SEL_FRM, SEL_CTA,
    SEL_XSTAT, SEL_XCTL, SEL_VER,
    SEL_SPT0, SEL_SPT1, SEL_SPT2, SEL_SPT3,
    SEL_GPL0, SEL_GPL1, SEL_GPL2, SEL_GPL3,
    SEL_JPL0, SEL_JPL1, SEL_JPL2, SEL_JPL3,
    SEL_BKCOL
  } regSel_e;

  typedef struct packed {
    logic            wrValid;
    regSel_e         wrSel;
    logic [HW-1:0]   wrHalf;
  } wrStrobe_t;

  // offset (low 7 bits of the folded address) to register
  function automatic regSel_e offDecode(input logic [6:0] off);
    regSel_e s;
    case (off)
      7'h00: s = SEL_PEND;
      7'h02: s = SEL_ENAB;
      7'h04: s = SEL_CLR;
      7'h20: s = SEL_DSTAT;
      7'h22: s = SEL_DCTL;
      7'h24: s = SEL_BRT0;
      7'h26: s = SEL_BRT1;
      7'h28: s = SEL_BRT2;
      7'h2A: s = SEL_REST;
      7'h2E: s = SEL_FRM;
      7'h30: s = SEL_CTA;
      7'h40: s = SEL_XSTAT;
      7'h42: s = SEL_XCTL;
      7'h44: s = SEL_VER;
      7'h48: s = SEL_SPT0;
      7'h4A: s = SEL_SPT1;
      7'h4C: s = SEL_SPT2;
      7'h4E: s = SEL_SPT3;
      7'h60: s = SEL_GPL0;
      7'h62: s = SEL_GPL1;
      7'h64: s = SEL_GPL2;
      7'h66: s = SEL_GPL3;
      7'h68: s = SEL_JPL0;
      7'h6A: s = SEL_JPL1;
      7'h6C: s = SEL_JPL2;
      7'h6E: s = SEL_JPL3;
      7'h70: s = SEL_BKCOL;
      default: s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/vreg_ctrl.sv
module vreg_ctrl
  import vreg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrEn,
  input  logic              accWord,
  input  logic [31:0]       wrData,
  output wrStrobe_t         wrStrb,
  output regSel_e           rdSel,
  output logic              busy
);

  localparam logic [ADDR_W-1:0] KEEP_M = ADDR_W'(FOLD_KEEP);
  localparam logic [ADDR_W-1:0] SET_M  = ADDR_W'(FOLD_SET);
  localparam logic [ADDR_W-1:0] STEP   = ADDR_W'(2);

  // fold an address into the window and pick the register
  function automatic regSel_e addrDecode(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] off;
    off = ((a & KEEP_M) | SET_M) ^ SET_M;
    if (off[ADDR_W-1:7] != '0) return SEL_NONE;
    return offDecode(off[6:0]);
  endfunction

  logic              busyQ;
  logic [ADDR_W-1:0] hiAddrQ;
  logic [HW-1:0]     hiDataQ;

  // second-half sequencer for word writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      hiAddrQ <= '0;
      hiDataQ <= '0;
    end else if (busyQ) begin
      busyQ <= 1'b0;
    end else if (wrEn && accWord) begin
      busyQ   <= 1'b1;
      hiAddrQ <= busAddr + STEP;
      hiDataQ <= wrData[31:16];
    end
  end

  always_comb begin
    if (busyQ) begin
      wrStrb.wrValid = 1'b1;
      wrStrb.wrSel   = addrDecode(hiAddrQ);
      wrStrb.wrHalf  = hiDataQ;
    end else begin
      wrStrb.wrValid = wrEn;
      wrStrb.wrSel   = addrDecode(busAddr);
      wrStrb.wrHalf  = wrData[15:0];
    end
  end

  assign rdSel = addrDecode(busAddr);
  assign busy  = busyQ;

  AST_WORD_SPLITS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && accWord && !busy) |=> busy) else $error("word write not split"); // R12
  AST_BUSY_ONE: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy) else $error("busy longer than one cycle"); // R12
  AST_HIGH_HALF: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && accWord && !busy) |=> (wrStrb.wrValid && wrStrb.wrHalf == $past(wrData[31:16])))
    else $error("high half not presented"); // R12

endmodule

// File: rtl/vreg_dpath.sv
module vreg_dpath
  import vreg_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  wrStrobe_t                 wrStrb,
  input  regSel_e                   rdSel,
  input  logic [HW-1:0]             evtSet,
  output logic [HW-1:0]             rdData,
  output logic                      irqOut,
  output logic [HW-1:0]             pendOut,
  output logic [HW-1:0]             enabOut,
  output logic [HW-1:0]             dispCtlOut,
  output logic [HW-1:0]             dispStatOut,
  output logic [HW-1:0]             drawCtlOut,
  output logic [HW-1:0]             drawStatOut,
  output logic [NUM_BRT*HW-1:0]     brightOut,
  output logic [NUM_BANK*HW-1:0]    bgPalOut,
  output logic [NUM_BANK*HW-1:0]    objPalOut,
  output logic [NUM_BANK*HW-1:0]    sprPtrOut,
  output logic [HW-1:0]             backColOut,
  output logic                      brtChg,
  output logic                      bgPalChg,
  output logic                      objPalChg
);

  localparam int SEL_W = $bits(regSel_e);

  logic [HW-1:0] pendQ, enabQ, dctlQ, dstatQ, xctlQ, xstatQ;
  logic [HW-1:0] restQ, frmQ, ctaQ, verQ, bkcolQ;
  logic [HW-1:0] pendN, enabN, dctlN, dstatN, xctlN, xstatN;
  logic [HW-1:0] restN, frmN, ctaN, verN, bkcolN;

  logic [NUM_BRT-1:0][HW-1:0]  brtQ;
  logic [NUM_BANK-1:0][HW-1:0] sptQ, gplQ, jplQ;

  logic [NUM_BRT-1:0]  brtHit;
  logic [NUM_BANK-1:0] sptHit, gplHit, jplHit;
  logic                bkcolHit;

  logic [HW-1:0] d;
  assign d = wrStrb.wrHalf;

  // one-hot write hits for repeated register groups
  for (genvar g = 0; g < NUM_BRT; g++) begin : gBrtHit
    assign brtHit[g] = wrStrb.wrValid &&
      (wrStrb.wrSel == regSel_e'(SEL_W'(int'(SEL_BRT0) + g)));
  end
  for (genvar g = 0; g < NUM_BANK; g++) begin : gBankHit
    assign sptHit[g] = wrStrb.wrValid &&
      (wrStrb.wrSel == regSel_e'(SEL_W'(int'(SEL_SPT0) + g)));
    assign gplHit[g] = wrStrb.wrValid &&
      (wrStrb.wrSel == regSel_e'(SEL_W'(int'(SEL_GPL0) + g)));
    assign jplHit[g] = wrStrb.wrValid &&
      (wrStrb.wrSel == regSel_e'(SEL_W'(int'(SEL_JPL0) + g)));
  end
  assign bkcolHit = wrStrb.wrValid && (wrStrb.wrSel == SEL_BKCOL);

  // interrupt, control and status next state
  always_comb begin
    pendN  = pendQ;
    enabN  = enabQ;
    dctlN  = dctlQ;
    dstatN = dstatQ;
    xctlN  = xctlQ;
    xstatN = xstatQ;
    restN  = restQ;
    frmN   = frmQ;
    ctaN   = ctaQ;
    verN   = verQ;
    bkcolN = bkcolHit ? d : bkcolQ;
    if (wrStrb.wrValid) begin
      case (wrStrb.wrSel)
        SEL_ENAB: enabN = d;
        SEL_CLR:  pendN = pendQ & ~d;
        SEL_DCTL: begin
          dctlN  = d & DCTL_KEEP;
          dstatN = (d & DSTAT_NEW) | (dstatQ & DSTAT_OLD);
          if (d[0]) begin
            pendN = pendQ & DRST_MASK;
            enabN = enabQ & DRST_MASK;
          end
        end
        SEL_XCTL: begin
          xctlN  = d & XCTL_KEEP;
          xstatN = (xstatQ & XSTAT_OLD) | (d & XSTAT_NEW);
          if (d[0]) begin
            pendN = pendQ & XRST_MASK;
            enabN = enabQ & XRST_MASK;
          end
        end
        SEL_REST: restN = d;
        SEL_FRM:  frmN  = d;
        SEL_CTA:  ctaN  = d;
        SEL_VER:  verN  = d;
        default: ;
      endcase
    end
    // events win over clears and reset masks
    pendN = pendN | evtSet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ  <= '0;
      enabQ  <= '0;
      dctlQ  <= '0;
      dstatQ <= '0;
      xctlQ  <= '0;
      xstatQ <= '0;
      restQ  <= '0;
      frmQ   <= '0;
      ctaQ   <= '0;
      verQ   <= '0;
      bkcolQ <= '0;
    end else begin
      pendQ  <= pendN;
      enabQ  <= enabN;
      dctlQ  <= dctlN;
      dstatQ <= dstatN;
      xctlQ  <= xctlN;
      xstatQ <= xstatN;
      restQ  <= restN;
      frmQ   <= frmN;
      ctaQ   <= ctaN;
      verQ   <= verN;
      bkcolQ <= bkcolN;
    end
  end

  // brightness and palette banks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      brtQ <= '0;
      sptQ <= '0;
      gplQ <= '0;
      jplQ <= '0;
    end else begin
      for (int i = 0; i < NUM_BRT; i++)
        if (brtHit[i]) brtQ[i] <= (d & BRT_DATA) | BRT_FIXED;
      for (int i = 0; i < NUM_BANK; i++) begin
        if (sptHit[i]) sptQ[i] <= d;
        if (gplHit[i]) gplQ[i] <= d;
        if (jplHit[i]) jplQ[i] <= d;
      end
    end
  end

  // change strobes, one cycle after the write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      brtChg    <= 1'b0;
      bgPalChg  <= 1'b0;
      objPalChg <= 1'b0;
    end else begin
      brtChg    <= |brtHit;
      bgPalChg  <= (|gplHit) | bkcolHit;
      objPalChg <= (|jplHit) | bkcolHit;
    end
  end

  // read mux
  always_comb begin
    case (rdSel)
      SEL_PEND:  rdData = pendQ;
      SEL_ENAB:  rdData = enabQ;
      SEL_CLR:   rdData = '0;
      SEL_DSTAT: rdData = dstatQ;
      SEL_DCTL:  rdData = dctlQ;
      SEL_BRT0:  rdData = brtQ[0];
      SEL_BRT1:  rdData = brtQ[1];
      SEL_BRT2:  rdData = brtQ[2];
      SEL_REST:  rdData = restQ;
      SEL_FRM:   rdData = frmQ;
      SEL_CTA:   rdData = ctaQ;
      SEL_XSTAT: rdData = xstatQ;
      SEL_XCTL:  rdData = xctlQ;
      SEL_VER:   rdData = verQ;
      SEL_SPT0:  rdData = sptQ[0];
      SEL_SPT1:  rdData = sptQ[1];
      SEL_SPT2:  rdData = sptQ[2];
      SEL_SPT3:  rdData = sptQ[3];
      SEL_GPL0:  rdData = gplQ[0];
      SEL_GPL1:  rdData = gplQ[1];
      SEL_GPL2:  rdData = gplQ[2];
      SEL_GPL3:  rdData = gplQ[3];
      SEL_JPL0:  rdData = jplQ[0];
      SEL_JPL1:  rdData = jplQ[1];
      SEL_JPL2:  rdData = jplQ[2];
      SEL_JPL3:  rdData = jplQ[3];
      SEL_BKCOL: rdData = bkcolQ;
      default:   rdData = NO_REG_VAL;
    endcase
  end

  assign irqOut      = |(pendQ & enabQ);
  assign pendOut     = pendQ;
  assign enabOut     = enabQ;
  assign dispCtlOut  = dctlQ;
  assign dispStatOut = dstatQ;
  assign drawCtlOut  = xctlQ;
  assign drawStatOut = xstatQ;
  assign brightOut   = brtQ;
  assign bgPalOut    = gplQ;
  assign objPalOut   = jplQ;
  assign sprPtrOut   = sptQ;
  assign backColOut  = bkcolQ;

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrb.wrValid && wrStrb.wrSel == SEL_CLR && evtSet == '0)
      |=> ((pendOut & $past(wrStrb.wrHalf)) == '0)) else $error("clear ignored"); // R2
  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (evtSet != '0) |=> ((pendOut & $past(evtSet)) == $past(evtSet))) else $error("event lost"); // R3
  AST_DISP_PRUNE: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrb.wrValid && wrStrb.wrSel == SEL_DCTL && wrStrb.wrHalf[0] && evtSet == '0)
      |=> (((pendOut | enabOut) & ~DRST_MASK) == '0)) else $error("display prune"); // R5
  AST_DRAW_PRUNE: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrb.wrValid && wrStrb.wrSel == SEL_XCTL && wrStrb.wrHalf[0] && evtSet == '0)
      |=> (((pendOut | enabOut) & ~XRST_MASK) == '0)) else $error("drawing prune"); // R7
  AST_DSTAT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrb.wrValid && wrStrb.wrSel == SEL_DCTL)
      |=> ((dispStatOut & DSTAT_OLD) == ($past(dispStatOut) & DSTAT_OLD))) else $error("display status"); // R4
  AST_BRT_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    brtChg |-> ($countones(brightOut & {NUM_BRT{16'hFE00}}) == 0)) else $error("brightness upper bits"); // R8
  AST_PEND_WR_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrb.wrValid && wrStrb.wrSel == SEL_PEND && evtSet == '0) |=> $stable(pendOut))
    else $error("pending written"); // R10

endmodule

// File: rtl/vid_irq_regfile.sv
module vid_irq_regfile
  import vreg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic                   wrEn,
  input  logic                   accWord,
  input  logic [31:0]            wrData,
  input  logic [15:0]            evtSet,
  output logic [15:0]            rdData,
  output logic                   busy,
  output logic                   irqOut,
  output logic [15:0]            pendOut,
  output logic [15:0]            enabOut,
  output logic [15:0]            dispCtlOut,
  output logic [15:0]            dispStatOut,
  output logic [15:0]            drawCtlOut,
  output logic [15:0]            drawStatOut,
  output logic [47:0]            brightOut,
  output logic [63:0]            bgPalOut,
  output logic [63:0]            objPalOut,
  output logic [63:0]            sprPtrOut,
  output logic [15:0]            backColOut,
  output logic                   brtChg,
  output logic                   bgPalChg,
  output logic                   objPalChg
);

  wrStrobe_t wrStrb;
  regSel_e   rdSel;

  vreg_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .wrEn    (wrEn),
    .accWord (accWord),
    .wrData  (wrData),
    .wrStrb  (wrStrb),
    .rdSel   (rdSel),
    .busy    (busy)
  );

  vreg_dpath uDpath (
    .clk         (clk),
    .rstN        (rstN),
    .wrStrb      (wrStrb),
    .rdSel       (rdSel),
    .evtSet      (evtSet),
    .rdData      (rdData),
    .irqOut      (irqOut),
    .pendOut     (pendOut),
    .enabOut     (enabOut),
    .dispCtlOut  (dispCtlOut),
    .dispStatOut (dispStatOut),
    .drawCtlOut  (drawCtlOut),
    .drawStatOut (drawStatOut),
    .brightOut   (brightOut),
    .bgPalOut    (bgPalOut),
    .objPalOut   (objPalOut),
    .sprPtrOut   (sprPtrOut),
    .backColOut  (backColOut),
    .brtChg      (brtChg),
    .bgPalChg    (bgPalChg),
    .objPalChg   (objPalChg)
  );

endmodule

// File: tb/sim_vid_irq_regfile.sv
module sim_vid_irq_regfile;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              wrEn = 1'b0;
  logic              accWord = 1'b0;
  logic [31:0]       wrData = '0;
  logic [15:0]       evtSet = '0;
  logic [15:0]       rdData;
  logic              busy, irqOut, brtChg, bgPalChg, objPalChg;
  logic [15:0]       pendOut, enabOut, dispCtlOut, dispStatOut, drawCtlOut, drawStatOut;
  logic [47:0]       brightOut;
  logic [63:0]       bgPalOut, objPalOut, sprPtrOut;
  logic [15:0]       backColOut;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_irq_regfile #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .wrEn(wrEn), .accWord(accWord),
    .wrData(wrData), .evtSet(evtSet), .rdData(rdData), .busy(busy), .irqOut(irqOut),
    .pendOut(pendOut), .enabOut(enabOut), .dispCtlOut(dispCtlOut),
    .dispStatOut(dispStatOut), .drawCtlOut(drawCtlOut), .drawStatOut(drawStatOut),
    .brightOut(brightOut), .bgPalOut(bgPalOut), .objPalOut(objPalOut),
    .sprPtrOut(sprPtrOut), .backColOut(backColOut), .brtChg(brtChg),
    .bgPalChg(bgPalChg), .objPalChg(objPalChg)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr16(input logic [31:0] a, input logic [15:0] v);
    @(negedge clk);
    busAddr = a; wrEn = 1'b1; accWord = 1'b0; wrData = {16'h0, v};
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd16(input logic [31:0] a, output logic [15:0] v);
    @(negedge clk);
    busAddr = a;
    #1 v = rdData;
  endtask

  task automatic pulseEvt(input logic [15:0] v);
    @(negedge clk);
    evtSet = v;
    @(negedge clk);
    evtSet = '0;
  endtask

  task automatic testReset();
    logic [15:0] v;
    rd16(32'h5F800, v); check("R1 pending", v, 16'h0);
    rd16(32'h5F822, v); check("R1 display ctl", v, 16'h0);
    check("R1 outputs", {irqOut, busy, brtChg, bgPalChg, objPalChg}, 0);
    check("R1 bright", brightOut, 0);
    check("R1 palettes", bgPalOut | objPalOut | sprPtrOut, 0);
  endtask

  task automatic testIrq();
    logic [15:0] v;
    wr16(32'h5F802, 16'h0011);
    pulseEvt(16'h0001);
    check("R3 pend after event", pendOut, 16'h0001);
    check("R3 irq high", irqOut, 1);
    pulseEvt(16'h0100);
    rd16(32'h5F800, v); check("R3 pend accum", v, 16'h0101);
    wr16(32'h5F804, 16'h0001);
    check("R2 clear", pendOut, 16'h0100);
    check("R3 irq masked", irqOut, 0);
    rd16(32'h5F804, v); check("R2 clear reads 0", v, 16'h0);
    // event and clear on the same bit, same cycle
    @(negedge clk);
    busAddr = 32'h5F804; wrEn = 1'b1; wrData = 32'h0101; evtSet = 16'h0100;
    @(negedge clk);
    wrEn = 1'b0; evtSet = '0;
    check("R3 event beats clear", pendOut, 16'h0100);
    wr16(32'h5F804, 16'h0100);
    check("R2 clear last", pendOut, 16'h0);
  endtask

  task automatic testDisplay();
    logic [15:0] v;
    wr16(32'h5F802, 16'hFFFF);
    pulseEvt(16'hFFFF);
    wr16(32'h5F822, 16'h0702);
    check("R5 no prune bit0 clear", pendOut, 16'hFFFF);
    wr16(32'h5F822, 16'hFFFF);
    rd16(32'h5F822, v); check("R4 display ctl", v, 16'h0703);
    rd16(32'h5F820, v); check("R4 display status", v, 16'h0702);
    check("R5 pend prune", pendOut, 16'h6000);
    check("R5 enab prune", enabOut, 16'h6000);
    wr16(32'h5F804, 16'hFFFF);
  endtask

  task automatic testDrawing();
    logic [15:0] v;
    wr16(32'h5F802, 16'hFFFF);
    pulseEvt(16'hFFFF);
    wr16(32'h5F842, 16'hFFFE);
    rd16(32'h5F842, v); check("R6 drawing ctl", v, 16'h1F02);
    rd16(32'h5F840, v); check("R6 drawing status", v, 16'h0002);
    check("R7 no prune bit0 clear", enabOut, 16'hFFFF);
    wr16(32'h5F842, 16'h0001);
    check("R7 pend prune", pendOut, 16'h001F);
    check("R7 enab prune", enabOut, 16'h001F);
    check("R6 drawing status bit1", drawStatOut, 16'h0000);
    check("R6 drawing ctl out", drawCtlOut, 16'h0001);
    wr16(32'h5F804, 16'hFFFF);
    wr16(32'h5F802, 16'h0000);
  endtask

  task automatic testBright();
    logic [15:0] v;
    wr16(32'h5F824, 16'hAB12);
    check("R8 strobe", brtChg, 1);
    rd16(32'h5F824, v); check("R8 value", v, 16'h0112);
    check("R8 strobe one cycle", brtChg, 0);
    wr16(32'h5F828, 16'h00FF);
    check("R8 level2", brightOut[47:32], 16'h01FF);
    check("R8 level0 kept", brightOut[15:0], 16'h0112);
  endtask

  task automatic testPalette();
    logic [15:0] v;
    wr16(32'h5F862, 16'hE4E4);
    check("R9 bg strobe", {bgPalChg, objPalChg}, 2'b10);
    check("R9 bg value", bgPalOut[31:16], 16'hE4E4);
    wr16(32'h5F86E, 16'h1B1B);
    check("R9 obj strobe", {bgPalChg, objPalChg}, 2'b01);
    check("R9 obj value", objPalOut[63:48], 16'h1B1B);
    wr16(32'h5F870, 16'h0C0C);
    check("R9 backdrop strobes", {bgPalChg, objPalChg}, 2'b11);
    rd16(32'h5F870, v); check("R9 backdrop read", v, 16'h0C0C);
    check("R9 strobes drop", {bgPalChg, objPalChg}, 2'b00);
  endtask

  task automatic testIgnored();
    logic [15:0] v;
    wr16(32'h5F840, 16'hFFFF);
    rd16(32'h5F840, v); check("R10 drawing status ro", v, 16'h0000);
    wr16(32'h5F820, 16'h0000);
    rd16(32'h5F820, v); check("R10 display status ro", v, 16'h0702);
    wr16(32'h5F800, 16'hFFFF);
    check("R10 pending ro", pendOut, 16'h0000);
    rd16(32'h5F806, v); check("R10 hole 06", v, 16'hFFFF);
    rd16(32'h5F87E, v); check("R10 hole 7E", v, 16'hFFFF);
  endtask

  task automatic testAlias();
    logic [15:0] v;
    wr16(32'h1234_0002, 16'h00A5);
    rd16(32'h5F802, v); check("R11 alias write", v, 16'h00A5);
    rd16(32'h0000_0070, v); check("R11 alias read", v, 16'h0C0C);
    wr16(32'h5F802, 16'h0000);
  endtask

  task automatic testWord();
    pulseEvt(16'h00FF);
    @(negedge clk);
    busAddr = 32'h5F802; wrEn = 1'b1; accWord = 1'b1; wrData = 32'h0004_00FF;
    @(negedge clk);
    check("R12 busy", busy, 1);
    check("R12 low half", enabOut, 16'h00FF);
    check("R12 high half pending", pendOut, 16'h00FF);
    // stray write during busy
    busAddr = 32'h5F870; accWord = 1'b0; wrData = 32'hDEAD;
    @(negedge clk);
    wrEn = 1'b0;
    check("R12 busy drops", busy, 0);
    check("R12 high half cleared", pendOut, 16'h00FB);
    check("R12 stray write dropped", backColOut, 16'h0C0C);
    @(negedge clk);
    busAddr = 32'h5F848; wrEn = 1'b1; accWord = 1'b1; wrData = 32'h2222_1111;
    @(negedge clk);
    wrEn = 1'b0; accWord = 1'b0;
    @(negedge clk);
    check("R12 pointer pair", sprPtrOut[31:0], 32'h2222_1111);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testIrq();
    testDisplay();
    testDrawing();
    testBright();
    testPalette();
    testIgnored();
    testAlias();
    testWord();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule